// File: doc/BRIEF.md
# Stop-and-Wait Half-Duplex Block Link Controller

This controller runs a stop-and-wait block transfer over one shared byte link on which only one end talks at a time. It can act as the sending end or as the receiving end. As sender, it leaves the idle line by bidding with an enquiry byte. Once the far end agrees, it streams fixed-length blocks out of an external block buffer. Each block is closed by an end-of-block byte, or by an end-of-transmission byte when it is the last one. After every block it waits for a positive or negative reply.

A negative reply or a silent far end leads to a resend, and a per-block attempt budget bounds the resends. When the budget runs out, the controller pulses an abort output and drops back to idle.

As receiver, it answers an incoming enquiry and passes the received data bytes out. It judges each block from a CRC-good flag supplied by an external checker, then replies positive or negative. When both ends bid at once, a parameter picks which end keeps the line. Serialisation and CRC arithmetic are outside the block.

Top module: `enq_link_ctrl`

## Requirements
- R1: After reset the controller is idle. `tx_valid_o`, `done_o`, `abort_o`, `rx_data_valid_o`, `rx_blk_ok_o` and `msg_rcvd_o` are all low.
- R2: In idle, `start_i` with a nonzero `msg_blocks_i` makes the controller send the enquiry byte 0x05 and latch the block count. When `msg_blocks_i` is zero, `start_i` is ignored.
- R3: An ACK byte (0x06) answering the enquiry starts block 0. Each block sends `BLK_BYTES` bytes read from the buffer at (`rd_blk_o`, `rd_idx_o`), with the index running upward from 0. The block then ends with 0x17 (EOB), or with 0x04 (EOT) when it is the last block.
- R4: An ACK after a non-last block starts the next block. An ACK after the last block gives a one-cycle `done_o` pulse and a return to idle.
- R5: A NAK byte (0x15) after a block resends the same block from index 0.
- R6: If no byte arrives for `TIMEOUT_CYC` cycles while a reply is awaited, the controller resends. The first resent byte appears exactly `TIMEOUT_CYC` cycles after the cycle in which the previous terminator or enquiry byte was accepted.
- R7: Each ACK clears the attempt counter. A NAK or timeout that arrives after `MAX_RETRY` resends of the same block or enquiry gives a one-cycle `abort_o` pulse, and the controller goes idle.
- R8: A NAK or a timeout after the enquiry resends the enquiry, under the same attempt budget as R7.
- R9: An enquiry received while idle is answered with ACK when `rx_ready_i` is high. Otherwise it is answered with NAK and the controller stays idle.
- R10: In the receive role, the first `BLK_BYTES` bytes of a block are forwarded on `rx_data_valid_o`/`rx_data_o`. The next byte must be EOB or EOT and must coincide with `crc_ok_i` high. In that case the controller pulses `rx_blk_ok_o` and replies ACK; on EOT it also pulses `msg_rcvd_o` and returns to idle. Any other case is answered with NAK, and the block is awaited again.
- R11: A byte on `tx_valid_o`/`tx_data_o` stays valid and unchanged until `tx_ready_i`. Nothing is transmitted while the controller awaits a reply or receives a block.
- R12: If an enquiry arrives while the controller awaits the answer to its own enquiry, the outcome depends on `IS_WINNER`. A winner (`IS_WINNER`=1) ignores the incoming enquiry. A loser drops its bid and answers as in R9.
- R13: In the receive role, if no byte arrives for `TIMEOUT_CYC` cycles, the controller returns to idle without any pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to send a message (sampled in idle) |
| msg_blocks_i | input | BW | Number of blocks in the message |
| tx_valid_o | output | 1 | Byte offered to the transmitter |
| tx_data_o | output | 8 | Byte to transmit |
| tx_ready_i | input | 1 | Transmitter accepts the offered byte |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| rx_ready_i | input | 1 | Local side can accept an incoming message |
| crc_ok_i | input | 1 | CRC-good for the block closed by the current byte |
| rd_blk_o | output | BW | Buffer read block number |
| rd_idx_o | output | IW | Buffer read byte index |
| rd_data_i | input | 8 | Buffer read data (combinational) |
| rx_data_valid_o | output | 1 | Received data byte strobe |
| rx_data_o | output | 8 | Received data byte |
| rx_blk_ok_o | output | 1 | Pulse: received block accepted |
| msg_rcvd_o | output | 1 | Pulse: last block of a message accepted |
| done_o | output | 1 | Pulse: message sent and acknowledged |
| abort_o | output | 1 | Pulse: attempt budget exhausted |

## Verification
Some rules are checked on every cycle by the assertions:

- the transmit byte holds while the transmitter stalls;
- the line stays silent in the waiting and receiving states;
- `done_o` only ever follows a received ACK, and `abort_o` only follows a NAK or an expired timer;
- accepted blocks always coincide with a good CRC;
- the timer and the attempt counter step correctly.

Other behaviour needs the bench's scenarios. These cover the byte order and terminators over swept block counts and NAK patterns, and the exact timeout gap. They also cover the abort after the last permitted attempt, the receive-side ACK/NAK decisions, and which side keeps the line in a collision.

// File: rtl/lk_pkg.sv
package lk_pkg;
  localparam logic [7:0] C_ENQ = 8'h05;
  localparam logic [7:0] C_ACK = 8'h06;
  localparam logic [7:0] C_NAK = 8'h15;
  localparam logic [7:0] C_EOT = 8'h04;
  localparam logic [7:0] C_EOB = 8'h17;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENQ,   // sending enquiry
    ST_WENQ,  // awaiting answer to enquiry
    ST_DATA,  // sending block payload
    ST_TERM,  // sending EOB/EOT
    ST_WBLK,  // awaiting block reply
    ST_REPLY, // sending ACK/NAK as receiver
    ST_RXD    // receiving block
  } lk_state_e;
endpackage

// File: rtl/lk_reply_timer.sv
module lk_reply_timer #(
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic expired_o
);
  localparam int unsigned CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;

  logic [CW-1:0] cnt_q;

  assign expired_o = run_i && !restart_i && (cnt_q == CW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (!run_i || restart_i || expired_o) cnt_q <= '0;
    else                                       cnt_q <= cnt_q + CW'(1);
  end

  a_r6_timer_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !restart_i && !expired_o) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  a_r13_timer_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/lk_retry_ctr.sv
module lk_retry_ctr #(
  parameter int unsigned MAX_RETRY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_limit_o
);
  localparam int unsigned RW = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;

  logic [RW-1:0] cnt_q;

  assign at_limit_o = (cnt_q == RW'(MAX_RETRY));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (inc_i && !at_limit_o) cnt_q <= cnt_q + RW'(1);
  end

  a_r7_retry_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !at_limit_o) |=> (cnt_q == $past(cnt_q) + RW'(1)));

  a_r7_retry_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= RW'(MAX_RETRY));
endmodule

// File: rtl/lk_tx_sel.sv
module lk_tx_sel
  import lk_pkg::*;
(
  input  lk_state_e  st_i,
  input  logic       last_i,
  input  logic [7:0] reply_i,
  input  logic [7:0] rd_data_i,
  output logic       valid_o,
  output logic [7:0] data_o
);
  always_comb begin
    valid_o = 1'b1;
    unique case (st_i)
      ST_ENQ:   data_o = C_ENQ;
      ST_DATA:  data_o = rd_data_i;
      ST_TERM:  data_o = last_i ? C_EOT : C_EOB;
      ST_REPLY: data_o = reply_i;
      default: begin
        valid_o = 1'b0;
        data_o  = 8'h00;
      end
    endcase
  end
endmodule

// File: rtl/enq_link_ctrl.sv
module enq_link_ctrl
  import lk_pkg::*;
#(
  parameter int unsigned BLK_BYTES   = 8,
  parameter int unsigned MAX_BLOCKS  = 16,
  parameter int unsigned TIMEOUT_CYC = 64,
  parameter int unsigned MAX_RETRY   = 3,
  parameter bit          IS_WINNER   = 1'b1,
  localparam int unsigned BW = $clog2(MAX_BLOCKS + 1),
  localparam int unsigned IW = $clog2(BLK_BYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [BW-1:0] msg_blocks_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  input  logic          tx_ready_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_ready_i,
  input  logic          crc_ok_i,
  output logic [BW-1:0] rd_blk_o,
  output logic [IW-1:0] rd_idx_o,
  input  logic [7:0]    rd_data_i,
  output logic          rx_data_valid_o,
  output logic [7:0]    rx_data_o,
  output logic          rx_blk_ok_o,
  output logic          msg_rcvd_o,
  output logic          done_o,
  output logic          abort_o
);
  lk_state_e     st_q;
  logic [BW-1:0] blk_q, nblk_q;
  logic [IW-1:0] idx_q, rx_cnt_q;
  logic [7:0]    reply_q;
  logic          reply_to_rx_q;

  logic rx_enq, rx_ack, rx_nak, rx_term, rx_eot;
  logic wait_st, tmo, at_limit, fail, last_blk, tx_fire, start_ok;
  logic rt_clr, rt_inc, tmr_run;

  assign rx_enq  = rx_valid_i && (rx_data_i == C_ENQ);
  assign rx_ack  = rx_valid_i && (rx_data_i == C_ACK);
  assign rx_nak  = rx_valid_i && (rx_data_i == C_NAK);
  assign rx_eot  = rx_data_i == C_EOT;
  assign rx_term = rx_eot || (rx_data_i == C_EOB);

  assign wait_st  = (st_q == ST_WENQ) || (st_q == ST_WBLK);
  assign fail     = wait_st && (rx_nak || tmo);
  assign last_blk = (blk_q == nblk_q - BW'(1));
  assign tx_fire  = tx_valid_o && tx_ready_i;
  assign start_ok = start_i && (msg_blocks_i != '0);

  assign tmr_run = wait_st || (st_q == ST_RXD);
  assign rt_inc  = fail && !at_limit;
  assign rt_clr  = (wait_st && rx_ack) || (st_q == ST_IDLE) ||
                   (st_q == ST_REPLY) || (st_q == ST_RXD);

  lk_reply_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (tmr_run),
    .restart_i (rx_valid_i),
    .expired_o (tmo)
  );

  lk_retry_ctr #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (rt_clr),
    .inc_i      (rt_inc),
    .at_limit_o (at_limit)
  );

  lk_tx_sel u_tx_sel (
    .st_i      (st_q),
    .last_i    (last_blk),
    .reply_i   (reply_q),
    .rd_data_i (rd_data_i),
    .valid_o   (tx_valid_o),
    .data_o    (tx_data_o)
  );

  assign rd_blk_o = blk_q;
  assign rd_idx_o = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q            <= ST_IDLE;
      blk_q           <= '0;
      nblk_q          <= '0;
      idx_q           <= '0;
      rx_cnt_q        <= '0;
      reply_q         <= C_NAK;
      reply_to_rx_q   <= 1'b0;
      rx_data_valid_o <= 1'b0;
      rx_data_o       <= '0;
      rx_blk_ok_o     <= 1'b0;
      msg_rcvd_o      <= 1'b0;
      done_o          <= 1'b0;
      abort_o         <= 1'b0;
    end else begin
      rx_data_valid_o <= 1'b0;
      rx_blk_ok_o     <= 1'b0;
      msg_rcvd_o      <= 1'b0;
      done_o          <= 1'b0;
      abort_o         <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (rx_enq && !(start_ok && IS_WINNER)) begin
            reply_q       <= rx_ready_i ? C_ACK : C_NAK;
            reply_to_rx_q <= rx_ready_i;
            st_q          <= ST_REPLY;
          end else if (start_ok) begin
            nblk_q <= msg_blocks_i;
            st_q   <= ST_ENQ;
          end
        end
        ST_ENQ: if (tx_fire) st_q <= ST_WENQ;
        ST_WENQ: begin
          if (rx_ack) begin
            blk_q <= '0;
            idx_q <= '0;
            st_q  <= ST_DATA;
          end else if (rx_enq && !IS_WINNER) begin
            // losing side of a simultaneous bid becomes the receiver
            reply_q       <= rx_ready_i ? C_ACK : C_NAK;
            reply_to_rx_q <= rx_ready_i;
            st_q          <= ST_REPLY;
          end else if (fail) begin
            if (at_limit) begin
              abort_o <= 1'b1;
              st_q    <= ST_IDLE;
            end else begin
              st_q <= ST_ENQ;
            end
          end
        end
        ST_DATA: begin
          if (tx_fire) begin
            if (idx_q == IW'(BLK_BYTES - 1)) st_q <= ST_TERM;
            else                             idx_q <= idx_q + IW'(1);
          end
        end
        ST_TERM: if (tx_fire) st_q <= ST_WBLK;
        ST_WBLK: begin
          if (rx_ack) begin
            if (last_blk) begin
              done_o <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              blk_q <= blk_q + BW'(1);
              idx_q <= '0;
              st_q  <= ST_DATA;
            end
          end else if (fail) begin
            idx_q <= '0;
            if (at_limit) begin
              abort_o <= 1'b1;
              st_q    <= ST_IDLE;
            end else begin
              st_q <= ST_DATA;
            end
          end
        end
        ST_REPLY: begin
          if (tx_fire) begin
            rx_cnt_q <= '0;
            st_q     <= reply_to_rx_q ? ST_RXD : ST_IDLE;
          end
        end
        ST_RXD: begin
          if (rx_valid_i) begin
            if (rx_cnt_q < IW'(BLK_BYTES)) begin
              rx_data_valid_o <= 1'b1;
              rx_data_o       <= rx_data_i;
              rx_cnt_q        <= rx_cnt_q + IW'(1);
            end else begin
              reply_q       <= (rx_term && crc_ok_i) ? C_ACK : C_NAK;
              reply_to_rx_q <= !(rx_term && crc_ok_i && rx_eot);
              rx_blk_ok_o   <= rx_term && crc_ok_i;
              msg_rcvd_o    <= rx_term && crc_ok_i && rx_eot;
              st_q          <= ST_REPLY;
            end
          end else if (tmo) begin
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r4_done_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(rx_valid_i && rx_data_i == C_ACK));

  a_r7_abort_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past((rx_valid_i && rx_data_i == C_NAK) || tmo));

  a_r4_pulse_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, abort_o, msg_rcvd_o}));

  a_r10_ok_needs_crc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_blk_ok_o |-> $past(crc_ok_i && rx_valid_i));

  a_r11_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  a_r11_quiet_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_st || st_q == ST_RXD) |-> !tx_valid_o);
endmodule

// File: tb/enq_link_ctrl_tb.sv
`timescale 1ns/1ps
module enq_link_ctrl_tb;
  localparam int BLK  = 3;
  localparam int MAXB = 4;
  localparam int TMO  = 12;
  localparam int MRET = 2;
  localparam int BW   = $clog2(MAXB + 1);
  localparam int IW   = $clog2(BLK + 1);

  localparam int ENQ = 8'h05, ACK = 8'h06, NAK = 8'h15, EOT = 8'h04, EOB = 8'h17;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start, rx_valid, rx_ready, crc_ok, tx_ready;
  logic [BW-1:0] msg_blocks;
  logic [7:0] rx_data;

  logic tx_valid, rx_dv, blk_ok, msg_rcvd, done, abort;
  logic [7:0] tx_data, rx_out, rd_data;
  logic [BW-1:0] rd_blk;
  logic [IW-1:0] rd_idx;

  logic tx_valid_l, rx_dv_l, blk_ok_l, msg_rcvd_l, done_l, abort_l;
  logic [7:0] tx_data_l, rx_out_l, rd_data_l;
  logic [BW-1:0] rd_blk_l;
  logic [IW-1:0] rd_idx_l;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign rd_data   = ((8'(rd_blk) << 4) | 8'(rd_idx)) ^ 8'hA5;
  assign rd_data_l = ((8'(rd_blk_l) << 4) | 8'(rd_idx_l)) ^ 8'hA5;

  enq_link_ctrl #(.BLK_BYTES(BLK), .MAX_BLOCKS(MAXB), .TIMEOUT_CYC(TMO),
                  .MAX_RETRY(MRET), .IS_WINNER(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .msg_blocks_i(msg_blocks),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_i(rx_ready),
    .crc_ok_i(crc_ok), .rd_blk_o(rd_blk), .rd_idx_o(rd_idx), .rd_data_i(rd_data),
    .rx_data_valid_o(rx_dv), .rx_data_o(rx_out), .rx_blk_ok_o(blk_ok),
    .msg_rcvd_o(msg_rcvd), .done_o(done), .abort_o(abort));

  enq_link_ctrl #(.BLK_BYTES(BLK), .MAX_BLOCKS(MAXB), .TIMEOUT_CYC(TMO),
                  .MAX_RETRY(MRET), .IS_WINNER(1'b0)) u_dut_l (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .msg_blocks_i(msg_blocks),
    .tx_valid_o(tx_valid_l), .tx_data_o(tx_data_l), .tx_ready_i(tx_ready),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_i(rx_ready),
    .crc_ok_i(crc_ok), .rd_blk_o(rd_blk_l), .rd_idx_o(rd_idx_l), .rd_data_i(rd_data_l),
    .rx_data_valid_o(rx_dv_l), .rx_data_o(rx_out_l), .rx_blk_ok_o(blk_ok_l),
    .msg_rcvd_o(msg_rcvd_l), .done_o(done_l), .abort_o(abort_l));

  function automatic int exp_byte(int b, int i);
    return (((b << 4) | i) ^ 'hA5) & 'hFF;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_tx_gap(int exp, string tag, output int gap);
    gap = 0;
    while (!tx_valid && gap < 400) begin
      @(negedge clk);
      gap++;
    end
    chk(tag, tx_valid ? int'(tx_data) : -1, exp);
    @(negedge clk);
  endtask

  task automatic expect_tx(int exp, string tag);
    int g;
    expect_tx_gap(exp, tag, g);
  endtask

  task automatic send_rx(int b);
    rx_valid = 1'b1;
    rx_data  = 8'(b);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; rx_valid = 1'b0; rx_data = '0;
    rx_ready = 1'b1; crc_ok = 1'b1; tx_ready = 1'b1; msg_blocks = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic kick(int nb);
    msg_blocks = BW'(nb);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic tx_block(int b, bit last, string tag);
    for (int i = 0; i < BLK; i++) expect_tx(exp_byte(b, i), tag);
    expect_tx(last ? EOT : EOB, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int g;
    do_reset();
    // R1 reset state
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 done/abort", {done, abort}, 0);
    chk("R1 rx pulses", {rx_dv, blk_ok, msg_rcvd}, 0);

    // R2 zero block count ignored
    msg_blocks = '0; start = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R2 zero count ignored", tx_valid, 0);
    end
    start = 1'b0;

    // R3 R4 R5 sweep over block counts and NAK patterns
    for (int nb = 1; nb <= MAXB; nb++) begin
      do_reset();
      kick(nb);
      expect_tx(ENQ, "R2 enquiry");
      send_rx(ACK);
      for (int b = 0; b < nb; b++) begin
        for (int k = 0; k < (b + nb) % 3; k++) begin
          tx_block(b, b == nb - 1, "R5 block before NAK");
          send_rx(NAK);
          chk("R5 no abort within budget", abort, 0);
        end
        tx_block(b, b == nb - 1, "R3 block bytes");
        send_rx(ACK);
        chk("R4 done pulse", done, (b == nb - 1) ? 1 : 0);
      end
      @(negedge clk);
      chk("R4 done one cycle", done, 0);
      chk("R4 idle after done", tx_valid, 0);
    end

    // R6 block reply timeout gap
    do_reset();
    kick(1);
    expect_tx(ENQ, "R6 enquiry");
    send_rx(ACK);
    tx_block(0, 1'b1, "R6 first attempt");
    expect_tx_gap(exp_byte(0, 0), "R6 resend after timeout", g);
    chk("R6 timeout gap", g, TMO);
    for (int i = 1; i < BLK; i++) expect_tx(exp_byte(0, i), "R6 resend bytes");
    expect_tx(EOT, "R6 resend terminator");
    send_rx(ACK);
    chk("R6 done after resend", done, 1);

    // R8 R7 enquiry retries then abort
    do_reset();
    kick(2);
    expect_tx(ENQ, "R8 enquiry 1");
    expect_tx_gap(ENQ, "R8 enquiry after timeout", g);
    chk("R8 enquiry timeout gap", g, TMO);
    send_rx(NAK);
    expect_tx(ENQ, "R8 enquiry after NAK");
    send_rx(NAK);
    chk("R7 abort on enquiry budget", abort, 1);
    for (int k = 0; k < TMO + 3; k++) begin
      @(negedge clk);
      if (k == 0) chk("R7 abort one cycle", abort, 0);
      chk("R7 idle after abort", tx_valid, 0);
    end

    // R7 block abort, counter restarts per block
    do_reset();
    kick(2);
    expect_tx(ENQ, "R7 enquiry");
    send_rx(NAK);
    expect_tx(ENQ, "R7 enquiry resend");
    send_rx(ACK);
    for (int a = 0; a <= MRET; a++) begin
      tx_block(0, 1'b0, "R7 attempt");
      send_rx(NAK);
      chk("R7 abort only on last attempt", abort, (a == MRET) ? 1 : 0);
    end
    @(negedge clk);
    chk("R7 idle after block abort", tx_valid, 0);

    // R11 transmit hold under stall
    do_reset();
    tx_ready = 1'b0;
    kick(1);
    for (int k = 0; k < 3; k++) begin
      chk("R11 hold valid", tx_valid, 1);
      chk("R11 hold data", tx_data, ENQ);
      @(negedge clk);
    end
    tx_ready = 1'b1;
    expect_tx(ENQ, "R11 released");
    for (int k = 0; k < 3; k++) begin
      chk("R11 silent while waiting", tx_valid, 0);
      @(negedge clk);
    end

    // R9 enquiry refused, then accepted
    do_reset();
    rx_ready = 1'b0;
    send_rx(ENQ);
    expect_tx(NAK, "R9 refuse");
    send_rx(8'h33);
    chk("R9 idle ignores data", rx_dv, 0);
    rx_ready = 1'b1;
    send_rx(ENQ);
    expect_tx(ACK, "R9 accept");

    // R10 receive role
    for (int i = 0; i < BLK; i++) begin
      send_rx(8'h40 + i);
      chk("R10 data strobe", rx_dv, 1);
      chk("R10 data value", rx_out, 8'h40 + i);
    end
    crc_ok = 1'b0;
    send_rx(EOB);
    chk("R10 bad crc no accept", blk_ok, 0);
    expect_tx(NAK, "R10 bad crc NAK");
    crc_ok = 1'b1;
    for (int i = 0; i < BLK; i++) send_rx(8'h40 + i);
    send_rx(EOB);
    chk("R10 block accepted", blk_ok, 1);
    chk("R10 EOB not end", msg_rcvd, 0);
    expect_tx(ACK, "R10 ACK");
    for (int i = 0; i < BLK; i++) send_rx(8'h50 + i);
    send_rx(8'h55);
    chk("R10 bad terminator", blk_ok, 0);
    expect_tx(NAK, "R10 bad terminator NAK");
    for (int i = 0; i < BLK; i++) send_rx(8'h50 + i);
    send_rx(EOT);
    chk("R10 last block accepted", blk_ok, 1);
    chk("R10 message received", msg_rcvd, 1);
    expect_tx(ACK, "R10 final ACK");
    send_rx(8'h77);
    chk("R10 idle after EOT", rx_dv, 0);

    // R13 receiver timeout
    do_reset();
    send_rx(ENQ);
    expect_tx(ACK, "R13 accept");
    send_rx(8'h11);
    repeat (TMO + 2) @(negedge clk);
    send_rx(8'h22);
    chk("R13 dropped to idle", rx_dv, 0);
    chk("R13 no pulse", {msg_rcvd, blk_ok, abort}, 0);
    send_rx(ENQ);
    expect_tx(ACK, "R13 idle answers enquiry");

    // R12 simultaneous enquiry
    do_reset();
    kick(1);
    chk("R12 winner bids", tx_valid ? int'(tx_data) : -1, ENQ);
    chk("R12 loser bids", tx_valid_l ? int'(tx_data_l) : -1, ENQ);
    @(negedge clk);
    send_rx(ENQ);
    chk("R12 winner ignores enquiry", tx_valid, 0);
    chk("R12 loser answers ACK", tx_valid_l ? int'(tx_data_l) : -1, ACK);
    send_rx(ACK);
    expect_tx(exp_byte(0, 0), "R12 winner proceeds");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule